// File: doc/BRIEF.md
# Strap-Addressed I2C Control Register Slave

This block is an I2C bus slave that holds one 8-bit control register. A host writes the register and reads it back over SCL/SDA. The slave drives SDA only as an open-drain pull-down. Three strap pins fix the slave's bus address on a base of 0x20 (7-bit), so up to eight of these slaves can share one bus. Downstream logic sees the register continuously on `ctrl_o`.

The register layout is:

| Bit | Meaning |
|-----|---------|
| 0 | Activation request (1) or deactivation (0) |
| 1 | Warm-reset request |
| 2 | Supply select, 1 = 3 V |
| 3 | Card clock halt |
| 4 | Level at which the halted clock rests |
| 5–6 | Card clock divider select |
| 7 | Data path enable |

Bit 1 is the one field that hardware can change without the host: it clears when the card starts answering or when the card is judged mute.

Both bus lines are resampled into the system clock domain through a synchronizer chain. Bus conditions are found from edges of the synchronized lines. A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Data moves MSB first and is sampled on rising SCL. The slave changes its SDA drive only while SCL is low. There is no clock stretching.

Top module: `i2c_strap_ctrl_reg`

## Requirements
- R1: After reset, `ctrl_o` is 0x00 and `sda_oe_o` is 0 (SDA released).
- R2: An address byte equal to 0x40 + 2*`strap_i` (R/W in bit 0, 7-bit address 0x20 + `strap_i`) is acknowledged: SDA is pulled low during the ninth SCL pulse.
- R3: Any other address byte gets no acknowledge. SDA stays released for the rest of the transfer, and data bytes sent after it leave `ctrl_o` unchanged.
- R4: In a write (R/W = 0), the eight data bits are taken MSB first and appear on `ctrl_o`. The slave acknowledges the byte with SDA low during the ninth pulse.
- R5: In a read (R/W = 1), the slave shifts the current register value out on SDA, MSB first, one bit per SCL pulse.
- R6: If the master acknowledges a read byte (SDA low on the ninth pulse), the register is sent again. If the master does not acknowledge, the slave keeps SDA released until the next START or STOP.
- R7: While `card_answer_i` or `card_mute_i` is high, bit 1 of the register is forced to 0 one clock later, even against a host write. The other bits are unaffected.
- R8: A STOP in the middle of a byte discards the partial byte. A repeated START restarts address reception.
- R9: Several data bytes in one write transfer each overwrite the register, so the last byte is the one that stays.
- R10: The slave's SDA drive changes only while SCL is low, so SDA is stable across every SCL high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| strap_i | input | 3 | Address select straps |
| card_answer_i | input | 1 | Card has begun answering; clears bit 1 |
| card_mute_i | input | 1 | Card declared mute; clears bit 1 |
| ctrl_o | output | 8 | Control register contents |

## Verification
The bench builds the block with its default parameters: a 3-bit strap, a two-stage synchronizer and a 7-bit base of 0x20. This small configuration keeps the full address family within reach of one run. For every strap value, the bench offers all eight family addresses plus one address outside the family. It checks acknowledge and register update arithmetically for each of these 72 pairs. Read-back, master acknowledge and no-acknowledge, the warm-bit clear against a write, aborted bytes and repeated START are then each exercised on a chosen strap.

// File: rtl/i2c_sreg_pkg.sv
package i2c_sreg_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_WR,
      ST_WACK,
      ST_RD,
      ST_MACK,
      ST_SKIP
   } slv_state_t;

   typedef struct packed {
      logic scl_lvl;
      logic scl_rise;
      logic scl_fall;
      logic start;
      logic stop;
      logic sda_lvl;
   } bus_evt_t;

endpackage

// File: rtl/i2c_sreg_sync.sv
module i2c_sreg_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] chain [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '1;
               else        chain[s] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '1;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/i2c_sreg_cond.sv
module i2c_sreg_cond
   import i2c_sreg_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_s,
   input  logic     sda_s,
   output bus_evt_t evt_o
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   always_comb begin
      evt_o.scl_lvl  = scl_s;
      evt_o.sda_lvl  = sda_s;
      evt_o.scl_rise = scl_s & ~scl_q;
      evt_o.scl_fall = ~scl_s & scl_q;
      evt_o.start    = scl_s & scl_q & sda_q & ~sda_s;
      evt_o.stop     = scl_s & scl_q & ~sda_q & sda_s;
   end
endmodule

// File: rtl/i2c_sreg_fsm.sv
module i2c_sreg_fsm
   import i2c_sreg_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bus_evt_t          evt_i,
   input  logic [ADDR_W-1:0] my_addr_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              wr_en_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              sda_oe_o,
   output slv_state_t        state_o
);
   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

   slv_state_t        state;
   logic [DATA_W-1:0] sh;
   logic [CNT_W-1:0]  cnt;
   logic              rw, oe, mack_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         sh        <= '0;
         cnt       <= '0;
         rw        <= 1'b0;
         oe        <= 1'b0;
         mack_ok   <= 1'b0;
         wr_en_o   <= 1'b0;
         wr_data_o <= '0;
      end else begin
         wr_en_o <= 1'b0;
         if (evt_i.start) begin
            state <= ST_ADDR;
            cnt   <= '0;
            oe    <= 1'b0;
         end else if (evt_i.stop) begin
            state <= ST_IDLE;
            oe    <= 1'b0;
         end else begin
            unique case (state)
               ST_ADDR: begin
                  if (evt_i.scl_rise) begin
                     sh  <= {sh[DATA_W-2:0], evt_i.sda_lvl};
                     cnt <= cnt + 1'b1;
                  end else if (evt_i.scl_fall && cnt == FULL) begin
                     if (sh[DATA_W-1:1] == my_addr_i) begin
                        rw    <= sh[0];
                        oe    <= 1'b1;
                        state <= ST_AACK;
                     end else begin
                        state <= ST_SKIP;
                     end
                  end
               end
               ST_AACK: begin
                  if (evt_i.scl_fall) begin
                     cnt <= '0;
                     if (rw) begin
                        sh    <= rd_data_i;
                        oe    <= ~rd_data_i[DATA_W-1];
                        state <= ST_RD;
                     end else begin
                        oe    <= 1'b0;
                        state <= ST_WR;
                     end
                  end
               end
               ST_WR: begin
                  if (evt_i.scl_rise) begin
                     sh  <= {sh[DATA_W-2:0], evt_i.sda_lvl};
                     cnt <= cnt + 1'b1;
                  end else if (evt_i.scl_fall && cnt == FULL) begin
                     wr_en_o   <= 1'b1;
                     wr_data_o <= sh;
                     oe        <= 1'b1;
                     state     <= ST_WACK;
                  end
               end
               ST_WACK: begin
                  if (evt_i.scl_fall) begin
                     oe    <= 1'b0;
                     cnt   <= '0;
                     state <= ST_WR;
                  end
               end
               ST_RD: begin
                  if (evt_i.scl_rise) begin
                     cnt <= cnt + 1'b1;
                  end else if (evt_i.scl_fall) begin
                     if (cnt == FULL) begin
                        oe    <= 1'b0;
                        state <= ST_MACK;
                     end else begin
                        sh <= {sh[DATA_W-2:0], 1'b0};
                        oe <= ~sh[DATA_W-2];
                     end
                  end
               end
               ST_MACK: begin
                  if (evt_i.scl_rise) begin
                     mack_ok <= ~evt_i.sda_lvl;
                  end else if (evt_i.scl_fall) begin
                     if (mack_ok) begin
                        cnt   <= '0;
                        sh    <= rd_data_i;
                        oe    <= ~rd_data_i[DATA_W-1];
                        state <= ST_RD;
                     end else begin
                        state <= ST_SKIP;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe_o = oe;
   assign state_o  = state;
endmodule

// File: rtl/i2c_sreg_store.sv
module i2c_sreg_store #(
   parameter int                DATA_W    = 8,
   parameter int                CLR_BIT   = 1,
   parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              hw_clr_i,
   output logic [DATA_W-1:0] q_o
);
   localparam logic [DATA_W-1:0] CLR_MASK = DATA_W'(1) << CLR_BIT;

   logic [DATA_W-1:0] nxt;

   always_comb begin
      nxt = wr_en_i ? wr_data_i : q_o;
      if (hw_clr_i) nxt = nxt & ~CLR_MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= RESET_VAL;
      else        q_o <= nxt;
   end
endmodule

// File: rtl/i2c_strap_ctrl_reg.sv
module i2c_strap_ctrl_reg
   import i2c_sreg_pkg::*;
#(
   parameter int                 REG_W       = 8,
   parameter int                 ADDR_W      = 7,
   parameter int                 STRAP_W     = 3,
   parameter logic [ADDR_W-1:0]  BASE_ADDR   = 7'h20,
   parameter int                 SYNC_STAGES = 2,
   parameter int                 WARM_BIT    = 1,
   parameter logic [REG_W-1:0]   RESET_VAL   = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   output logic               sda_oe_o,
   input  logic [STRAP_W-1:0] strap_i,
   input  logic               card_answer_i,
   input  logic               card_mute_i,
   output logic [REG_W-1:0]   ctrl_o
);
   localparam int STRAP_SPAN = 1 << STRAP_W;

   generate
      if (REG_W != 8) begin : g_bad_width
         $error("REG_W must be 8: one byte per bus transfer");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (STRAP_W >= ADDR_W) begin : g_bad_strap
         $error("STRAP_W must be narrower than ADDR_W");
      end
      if ((int'(BASE_ADDR) % STRAP_SPAN) != 0) begin : g_bad_base
         $error("BASE_ADDR low bits must be zero under the strap field");
      end
      if (WARM_BIT >= REG_W) begin : g_bad_warm
         $error("WARM_BIT out of range");
      end
   endgenerate

   logic [1:0]        line_s;
   bus_evt_t          evt;
   logic [ADDR_W-1:0] my_addr;
   logic              wr_en;
   logic [REG_W-1:0]  wr_data;
   slv_state_t        fsm_state;
   logic              hw_clr;

   i2c_sreg_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  ({scl_i, sda_i}),
      .q_o  (line_s)
   );

   i2c_sreg_cond cond_i (
      .clk  (clk),
      .rst_n(rst_n),
      .scl_s(line_s[1]),
      .sda_s(line_s[0]),
      .evt_o(evt)
   );

   assign my_addr = BASE_ADDR | ADDR_W'(strap_i);
   assign hw_clr  = card_answer_i | card_mute_i;

   i2c_sreg_fsm #(.ADDR_W(ADDR_W), .DATA_W(REG_W)) fsm_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (evt),
      .my_addr_i(my_addr),
      .rd_data_i(ctrl_o),
      .wr_en_o  (wr_en),
      .wr_data_o(wr_data),
      .sda_oe_o (sda_oe_o),
      .state_o  (fsm_state)
   );

   i2c_sreg_store #(.DATA_W(REG_W), .CLR_BIT(WARM_BIT), .RESET_VAL(RESET_VAL)) store_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en_i  (wr_en),
      .wr_data_i(wr_data),
      .hw_clr_i (hw_clr),
      .q_o      (ctrl_o)
   );
endmodule

// File: rtl/i2c_strap_ctrl_reg_chk.sv
module i2c_strap_ctrl_reg_chk
   import i2c_sreg_pkg::*;
#(
   parameter int               REG_W     = 8,
   parameter int               WARM_BIT  = 1,
   parameter logic [REG_W-1:0] RESET_VAL = '0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sda_oe,
   input logic [REG_W-1:0] ctrl,
   input logic             scl_lvl,
   input logic             wr_en,
   input slv_state_t       state,
   input logic             clr
);
   localparam logic [REG_W-1:0] KEEP = ~(REG_W'(1) << WARM_BIT);

   a_r1_reset_state: assert property (@(posedge clk)
      !rst_n |-> (ctrl == RESET_VAL && !sda_oe));

   a_r10_drive_only_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_lvl);

   a_r7_warm_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !ctrl[WARM_BIT]);

   a_r4_change_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ctrl & KEEP) |-> $past(wr_en));

   a_r3_no_drive_unselected: assert property (@(posedge clk) disable iff (!rst_n)
      sda_oe |-> (state != ST_IDLE && state != ST_SKIP));
endmodule

bind i2c_strap_ctrl_reg i2c_strap_ctrl_reg_chk #(
   .REG_W(REG_W), .WARM_BIT(WARM_BIT), .RESET_VAL(RESET_VAL)
) chk_i (
   .clk    (clk),
   .rst_n  (rst_n),
   .sda_oe (sda_oe_o),
   .ctrl   (ctrl_o),
   .scl_lvl(evt.scl_lvl),
   .wr_en  (wr_en),
   .state  (fsm_state),
   .clr    (hw_clr)
);

// File: tb/i2c_strap_ctrl_reg_tb_top.sv
module i2c_strap_ctrl_reg_tb_top;
   localparam int Q = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic [2:0] strap = 3'd0;
   logic       ans = 1'b0;
   logic       mute = 1'b0;
   logic       sda_oe;
   logic [7:0] ctrl;
   logic       sda_line;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;

   i2c_strap_ctrl_reg dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .scl_i        (scl_m),
      .sda_i        (sda_line),
      .sda_oe_o     (sda_oe),
      .strap_i      (strap),
      .card_answer_i(ans),
      .card_mute_i  (mute),
      .ctrl_o       (ctrl)
   );

   task automatic check(input logic [7:0] got, input logic [7:0] exp, input string req);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
      end
   endtask

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bstart();
      sda_m = 1'b1; wq(Q);
      scl_m = 1'b1; wq(Q);
      sda_m = 1'b0; wq(Q);
      scl_m = 1'b0; wq(Q);
   endtask

   task automatic bstop();
      sda_m = 1'b0; wq(Q);
      scl_m = 1'b1; wq(Q);
      sda_m = 1'b1; wq(Q);
   endtask

   task automatic bit_clk(input logic b, output logic s1, output logic s2);
      sda_m = b; wq(Q);
      scl_m = 1'b1; wq(Q);
      s1 = sda_line; wq(Q - 1);
      s2 = sda_line; wq(1);
      scl_m = 1'b0; wq(Q);
   endtask

   task automatic send_byte(input logic [7:0] v, output logic ack);
      logic a, b;
      for (int i = 7; i >= 0; i--) bit_clk(v[i], a, b);
      bit_clk(1'b1, a, b);
      ack = ~a;
   endtask

   task automatic recv_byte(input logic master_ack, output logic [7:0] v, output logic stable);
      logic a, b;
      stable = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         bit_clk(1'b1, a, b);
         v[i] = a;
         if (a !== b) stable = 1'b0;
      end
      bit_clk(~master_ack, a, b);
   endtask

   task automatic write_reg(input logic [7:0] abyte, input logic [7:0] d,
                            output logic aack, output logic dack);
      bstart();
      send_byte(abyte, aack);
      send_byte(d, dack);
      bstop();
   endtask

   initial begin
      int unsigned wd = 0;
      while (wd < 190000) begin
         @(posedge clk);
         wd++;
      end
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic       aa, da, st;
      logic [7:0] rv, expv, abyte, d;

      wq(5);
      check(ctrl, 8'h00, "R1 reset ctrl");
      check({7'd0, sda_oe}, 8'h00, "R1 reset sda released");
      rst_n = 1'b1;
      wq(5);

      // R2, R3, R4 sweep: every strap against every family address plus one outside
      expv = 8'h00;
      for (int s = 0; s < 8; s++) begin
         strap = 3'(s);
         wq(Q);
         for (int c = 0; c < 9; c++) begin
            abyte = 8'(8'h40 + 2 * c);
            d = 8'((s * 37 + c * 11 + 3) & 8'hFD);
            write_reg(abyte, d, aa, da);
            if (c == s) begin
               expv = d;
               check({7'd0, aa}, 8'h01, "R2 address ack");
               check({7'd0, da}, 8'h01, "R4 data ack");
               check(ctrl, expv, "R4 written value");
            end else begin
               check({7'd0, aa}, 8'h00, "R3 no ack on mismatch");
               check({7'd0, da}, 8'h00, "R3 data not acked");
               check(ctrl, expv, "R3 register unchanged");
            end
         end
      end

      // R5, R10: read back several values on strap 5
      strap = 3'd5;
      wq(Q);
      for (int k = 0; k < 6; k++) begin
         d = 8'((k * 73 + 5) & 8'hFD);
         write_reg(8'h4A, d, aa, da);
         bstart();
         send_byte(8'h4B, aa);
         check({7'd0, aa}, 8'h01, "R2 read address ack");
         recv_byte(1'b0, rv, st);
         bstop();
         check(rv, d, "R5 read value");
         check({7'd0, st}, 8'h01, "R10 SDA stable while SCL high");
      end

      // R6: master ack repeats, master nack releases
      write_reg(8'h4A, 8'hC4, aa, da);
      bstart();
      send_byte(8'h4B, aa);
      recv_byte(1'b1, rv, st);
      check(rv, 8'hC4, "R6 first byte");
      recv_byte(1'b0, rv, st);
      check(rv, 8'hC4, "R6 repeated byte after master ack");
      recv_byte(1'b0, rv, st);
      check(rv, 8'hFF, "R6 released after master nack");
      bstop();

      // R7: clear held during write of all ones
      mute = 1'b1;
      write_reg(8'h4A, 8'hFF, aa, da);
      mute = 1'b0;
      check(ctrl, 8'hFD, "R7 warm bit forced low during write");
      write_reg(8'h4A, 8'h02, aa, da);
      check(ctrl, 8'h02, "R7 warm bit set without clear");
      ans = 1'b1;
      wq(1);
      ans = 1'b0;
      wq(2);
      check(ctrl, 8'h00, "R7 warm bit cleared by answer");

      // R8: stop mid-byte discards
      write_reg(8'h4A, 8'h81, aa, da);
      bstart();
      send_byte(8'h4A, aa);
      for (int i = 0; i < 4; i++) bit_clk(1'b0, aa, st);
      bstop();
      check(ctrl, 8'h81, "R8 partial byte discarded on stop");

      // R8: repeated start restarts addressing
      bstart();
      send_byte(8'h4A, aa);
      for (int i = 0; i < 3; i++) bit_clk(1'b1, aa, st);
      bstart();
      send_byte(8'h4A, aa);
      check({7'd0, aa}, 8'h01, "R8 address ack after repeated start");
      send_byte(8'h3C, da);
      bstop();
      check(ctrl, 8'h3C, "R8 write after repeated start");

      // R9: multiple bytes, last wins
      bstart();
      send_byte(8'h4A, aa);
      send_byte(8'h11, da);
      check({7'd0, da}, 8'h01, "R9 first data ack");
      check(ctrl, 8'h11, "R9 first byte stored");
      send_byte(8'h64, da);
      check({7'd0, da}, 8'h01, "R9 second data ack");
      bstop();
      check(ctrl, 8'h64, "R9 last byte kept");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule